// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider for a Frequency Synthesizer

This block is the programmable counter stage that sits behind a 32/33 dual-modulus prescaler in a phase-locked loop. It runs on the prescaler's output clock. It produces two outputs: a modulus-select signal that tells the prescaler whether to divide by 33 or by 32, and a single-cycle feedback pulse that goes to the phase/frequency detector. Over one output period the VCO frequency is divided by N = 32·M + A.

A 17-bit control word carries the main count M in its upper 11 bits and the swallow count A in its lower 6 bits. At the start of each output period a swallow counter loads A and a main counter loads M. The prescaler is held in divide-by-33 for the first A prescaler cycles. It then divides by 32 for the rest of the M cycles. A word written in the middle of a period is only picked up at the terminal count, so a running period is never cut short. A swallow count larger than the main count is clamped, and a flag marks that the clamp is in effect.

Top module: `pswallow_div`

## Requirements
- R1: The control word is split as M = bits [16:6] and A = bits [5:0].
- R2: `fb_pulse` is high in the last cycle of each period and in no other cycle. A period lasts M_eff prescaler cycles, where M_eff = M. With M_eff = 1, `fb_pulse` stays high.
- R3: `mod_sel` (1 = divide by 33, 0 = divide by 32) is high for the first A_eff cycles of each period and low for the rest of that period.
- R4: Each period spans 32·M_eff + A_eff VCO cycles when each prescaler cycle is weighted 33 if `mod_sel` is high and 32 if it is low.
- R5: The control word is sampled only at the clock edge that ends a pulse cycle. A change in the middle of a period leaves the length, the modulus pattern and the flag of that period unchanged.
- R6: If A > M_eff, then A_eff = M_eff and `clamp_flag` is high for the whole period that uses that word. Otherwise A_eff = A and `clamp_flag` is low.
- R7: A synchronous active-high reset loads the word that is present at the reset edge. The first cycle after the last reset edge is cycle 1 of a new period, and this also holds when reset arrives in the middle of a period.
- R8: A main count of M = 0 is treated as M_eff = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 17 | Division word: M in [16:6], A in [5:0] |
| mod_sel | output | 1 | Prescaler modulus select, 1 = divide by 33 |
| fb_pulse | output | 1 | One-cycle feedback pulse to the phase detector |
| clamp_flag | output | 1 | The current period uses a clamped swallow count |

## Verification
All three outputs are decoded directly from registered counter state. Each one therefore changes one clock edge after the edge that loads or steps the counters, and it holds steady for the rest of that clock cycle. A new word is loaded at the edge that closes the pulse cycle, so its effects first show up in the cycle that follows that edge. The bench drives and samples only on falling edges. It treats the cycle in which the pulse is seen as the final cycle of a period, and it measures the next period starting at the following falling edge. It accumulates length, modulus count, modulus order, weighted VCO cycles and the flag across every cycle of that period.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

    localparam int MAIN_W    = 11;
    localparam int SWAL_W    = 6;
    localparam int CW_W      = MAIN_W + SWAL_W;
    localparam int PRESC_LOW = 32;

    typedef enum logic {
        MOD_BASE  = 1'b0,
        MOD_PLUS1 = 1'b1
    } modsel_e;

    typedef struct packed {
        logic [MAIN_W-1:0] m;
        logic [SWAL_W-1:0] a;
        logic              clamp;
    } div_cfg_t;

    function automatic div_cfg_t decode_word(input logic [CW_W-1:0] w);
        div_cfg_t          c;
        logic [MAIN_W-1:0] m_raw;
        logic [MAIN_W-1:0] a_ext;
        m_raw = w[CW_W-1:SWAL_W];
        c.m   = (m_raw == '0) ? MAIN_W'(1) : m_raw;
        a_ext = MAIN_W'(w[SWAL_W-1:0]);
        if (a_ext > c.m) begin
            c.a     = c.m[SWAL_W-1:0];
            c.clamp = 1'b1;
        end else begin
            c.a     = w[SWAL_W-1:0];
            c.clamp = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/pswd_main_cnt.sv
module pswd_main_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    output logic         tc
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (reload) begin
            cnt <= load_val;
        end else begin
            cnt <= cnt - W'(1);
        end
    end

    assign tc = (cnt == '0);
endmodule

// File: rtl/pswd_swallow_cnt.sv
module pswd_swallow_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    output logic         active
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (reload) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/pswd_flag_reg.sv
module pswd_flag_reg (
    input  logic clk,
    input  logic reload,
    input  logic flag_in,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (reload) begin
            flag_q <= flag_in;
        end
    end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
    import pswd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [CW_W-1:0] ctrl_word,
    output logic            mod_sel,
    output logic            fb_pulse,
    output logic            clamp_flag
);
    div_cfg_t          cfg;
    logic              tc;
    logic              reload;
    logic              swal_active;
    logic [MAIN_W-1:0] main_load;
    modsel_e           ms;

    always_comb cfg = decode_word(ctrl_word);

    // counters restart on reset or at terminal count
    assign reload    = rst | tc;
    assign main_load = cfg.m - MAIN_W'(1);

    pswd_main_cnt #(.W(MAIN_W)) u_main (
        .clk      (clk),
        .reload   (reload),
        .load_val (main_load),
        .tc       (tc)
    );

    pswd_swallow_cnt #(.W(SWAL_W)) u_swal (
        .clk      (clk),
        .reload   (reload),
        .load_val (cfg.a),
        .active   (swal_active)
    );

    pswd_flag_reg u_flag (
        .clk     (clk),
        .reload  (reload),
        .flag_in (cfg.clamp),
        .flag_q  (clamp_flag)
    );

    assign ms       = swal_active ? MOD_PLUS1 : MOD_BASE;
    assign mod_sel  = (ms == MOD_PLUS1);
    assign fb_pulse = tc;
endmodule

// File: rtl/pswd_checker.sv
module pswd_checker (
    input logic        clk,
    input logic        rst,
    input logic [16:0] ctrl_word,
    input logic        mod_sel,
    input logic        fb_pulse,
    input logic        clamp_flag
);
    logic [10:0] w_m;
    logic [10:0] w_meff;
    logic [10:0] w_aext;
    logic [11:0] cap_m;
    logic [11:0] cap_a;
    logic        cap_clamp;
    logic [11:0] cnt;

    always_comb begin
        w_m    = ctrl_word[16:6];
        w_meff = (w_m == 11'd0) ? 11'd1 : w_m;
        w_aext = {5'd0, ctrl_word[5:0]};
    end

    always_ff @(posedge clk) begin
        if (rst || fb_pulse) begin
            cnt       <= 12'd0;
            cap_m     <= {1'b0, w_meff};
            cap_a     <= (w_aext > w_meff) ? {1'b0, w_meff} : {1'b0, w_aext};
            cap_clamp <= (w_aext > w_meff);
        end else begin
            cnt <= cnt + 12'd1;
        end
    end

    a_r2_pulse_at_end: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |-> (cnt == cap_m - 12'd1));

    a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
        !fb_pulse |-> (cnt < cap_m - 12'd1));

    a_r3_mod_window: assert property (@(posedge clk) disable iff (rst)
        mod_sel == (cnt < cap_a));

    a_r6_clamp_flag: assert property (@(posedge clk) disable iff (rst)
        clamp_flag == cap_clamp);

    a_r5_flag_steady: assert property (@(posedge clk) disable iff (rst)
        (!$past(fb_pulse) && !$past(rst)) |-> $stable(clamp_flag));
endmodule

bind pswallow_div pswd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_word  (ctrl_word),
    .mod_sel    (mod_sel),
    .fb_pulse   (fb_pulse),
    .clamp_flag (clamp_flag)
);

// File: tb/sim_pswallow_div.sv
module sim_pswallow_div;
    logic        clk = 1'b0;
    logic        rst;
    logic [16:0] ctrl_word;
    logic        mod_sel;
    logic        fb_pulse;
    logic        clamp_flag;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #10 clk = ~clk;

    pswallow_div u0 (
        .clk        (clk),
        .rst        (rst),
        .ctrl_word  (ctrl_word),
        .mod_sel    (mod_sel),
        .fb_pulse   (fb_pulse),
        .clamp_flag (clamp_flag)
    );

    // {M, A, expected length, expected 33-cycles, expected VCO cycles, expected flag}
    localparam int NV = 10;
    localparam int VEC [NV][6] = '{
        '{ 5,  2,  5,  2,  162, 0},
        '{ 3,  0,  3,  0,   96, 0},
        '{ 4,  4,  4,  4,  132, 0},
        '{ 3,  7,  3,  3,   99, 1},
        '{ 0,  0,  1,  0,   32, 0},
        '{ 1,  1,  1,  1,   33, 0},
        '{ 0,  5,  1,  1,   33, 1},
        '{20, 63, 20, 20,  660, 1},
        '{64, 63, 64, 63, 2111, 0},
        '{ 2,  1,  2,  1,   65, 0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [16:0] mkw(input int m, input int a);
        logic [10:0] mm;
        logic [5:0]  aa;
        mm = m[10:0];
        aa = a[5:0];
        return {mm, aa};   // R1: M in [16:6], A in [5:0]
    endfunction

    // Entered at the falling edge of cycle 1 of a period; leaves at the pulse cycle.
    task automatic measure(input int em, input int ea, input int en, input int ef,
                           input string tag, input int chg_at, input logic [16:0] chg_w);
        int len = 0;
        int highs = 0;
        int sum = 0;
        bit order_ok = 1'b1;
        bit flag_ok = 1'b1;
        bit seen_low = 1'b0;
        while (1) begin
            len++;
            if (mod_sel === 1'b1) begin
                highs++;
                sum += 33;
                if (seen_low) order_ok = 1'b0;
            end else begin
                sum += 32;
                seen_low = 1'b1;
            end
            if (clamp_flag !== ef[0]) flag_ok = 1'b0;
            if (len == chg_at) ctrl_word = chg_w;
            if (fb_pulse === 1'b1 || len >= 4000) break;
            @(negedge clk);
        end
        chk(len == em,   $sformatf("R2 period length %s", tag), len, em);
        chk(highs == ea, $sformatf("R3 divide-by-33 cycles %s", tag), highs, ea);
        chk(order_ok,    $sformatf("R3 33-cycles lead the period %s", tag), int'(order_ok), 1);
        chk(sum == en,   $sformatf("R4 VCO cycles per period %s", tag), sum, en);
        chk(flag_ok,     $sformatf("R6 clamp flag steady %s", tag), int'(flag_ok), 1);
    endtask

    initial begin
        rst       = 1'b1;
        ctrl_word = mkw(3, 9);
        repeat (3) @(negedge clk);
        // R7: reset loads the word present at the reset edge
        chk(fb_pulse === 1'b0,   "R7 reset pulse low", int'(fb_pulse), 0);
        chk(mod_sel === 1'b1,    "R7 reset mod_sel high", int'(mod_sel), 1);
        chk(clamp_flag === 1'b1, "R7 reset clamp flag", int'(clamp_flag), 1);
        rst = 1'b0;
        measure(3, 3, 99, 1, "R7 first period", 0, '0);

        // table of vectors: R1 R2 R3 R4 R6 R8
        for (int i = 0; i < NV; i++) begin
            ctrl_word = mkw(VEC[i][0], VEC[i][1]);
            @(negedge clk);
            measure(VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5],
                    $sformatf("R1 vector %0d", i), 0, '0);
        end

        // R5: change mid-period to a clamping word; current period unaffected
        ctrl_word = mkw(10, 3);
        @(negedge clk);
        measure(10, 3, 323, 0, "R5 before change", 4, mkw(2, 5));
        @(negedge clk);
        measure(2, 2, 66, 1, "R5 after change", 0, '0);

        // R7: reset in the middle of a period restarts with the new word
        ctrl_word = mkw(7, 2);
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst       = 1'b1;
        ctrl_word = mkw(4, 1);
        @(negedge clk);
        rst = 1'b0;
        measure(4, 1, 129, 0, "R7 mid-period reset", 0, '0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule